// File: doc/BRIEF.md
# Register Bank with Multiplexed Hex Display

The block stores four 4-bit unsigned values. A shared 4-bit switch bus supplies the data. Each register has its own push-button load strobe. When a strobe is high at a rising clock edge, that register captures the bus. The registers only read the bus and never drive it.

All four values are shown on four common-anode seven-segment digits that share one 8-bit segment bus. A divider produces a one-cycle tick every `TICK_DIV` clocks. Each tick moves a round-robin scan to the next slot. In slot k, register k goes through a hex glyph decoder onto the segment bus, and only digit k is enabled.

Segment lines and digit enables are both active low. Everything runs in the single input clock domain. Button debouncing is left to the surrounding logic.

Top module: `hex_bank_display`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, all registers read 0 and the scan sits in slot 0. The outputs are therefore `an_o = 4'b1110` and `seg_o = 8'h03`.
- R2: When `btn_i[k]` is high at a rising edge, register k takes the value of `sw_i` at that edge. The value shows on digit k whenever slot k is active.
- R3: A register whose button is low keeps its value, whatever `sw_i` does.
- R4: When several buttons are high in the same cycle, every selected register loads the same `sw_i` value.
- R5: The segment bit order and levels are fixed:
  - bit 7 is segment A, bits 6 to 1 are B to G, and bit 0 is the decimal point;
  - a 0 lights a segment;
  - the decimal point is always 1 (off);
  - value 15 gives `8'h71`.
- R6: Values 0 to 15 decode to the glyphs 0 to 9, A, b, C, d, E and F. Each glyph uses its usual lit-segment pattern.
- R7: The scan visits slots 0, 1, 2, 3 and then 0 again. In slot k, `an_o[k]` is 0 and all other enable bits are 1.
- R8: Every slot lasts exactly `TICK_DIV` clock cycles.
- R9: In slot k, `seg_o` is the glyph of register k's current content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_i | input | 4 | Shared data bus from the switches |
| btn_i | input | 4 | Per-register load strobes; bit k loads register k |
| seg_o | output | 8 | Active-low segment bus: A at bit 7 down to the decimal point at bit 0 |
| an_o | output | 4 | Active-low digit enables; bit k enables digit k |

## Verification
The bench loads every value 0 to 15 into every register. After each load it waits for that register's slot and compares the glyph with one computed from per-segment lit masks.

This targets two kinds of error:
- A swapped segment order or a wrong table entry would show a wrong glyph for some value.
- A mis-indexed load or display path would put a value on the wrong digit.

The bench also counts the length of every slot, which catches an off-by-one divider. It toggles the switches with all buttons released, which catches a register that loads without its strobe. It strikes all buttons together to prove that a multi-load fills every register. Finally, it pulses reset mid-scan to prove that the registers and the scan both return to their initial state.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned NIBBLE_W = 4;
  localparam int unsigned SEG_W    = 8;

  typedef logic [NIBBLE_W-1:0] nibble_t;
  typedef logic [SEG_W-1:0]    seg_t;

  // Active-low glyphs, {A,B,C,D,E,F,G,DP}
  function automatic seg_t hex_glyph(input nibble_t v);
    seg_t g;
    unique case (v)
      4'h0: g = 8'h03;
      4'h1: g = 8'h9F;
      4'h2: g = 8'h25;
      4'h3: g = 8'h0D;
      4'h4: g = 8'h99;
      4'h5: g = 8'h49;
      4'h6: g = 8'h41;
      4'h7: g = 8'h1F;
      4'h8: g = 8'h01;
      4'h9: g = 8'h09;
      4'hA: g = 8'h11;
      4'hB: g = 8'hC1;
      4'hC: g = 8'h63;
      4'hD: g = 8'h85;
      4'hE: g = 8'h61;
      default: g = 8'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/hbd_regfile.sv
module hbd_regfile
  import hbd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  nibble_t                           wr_data_i,
  input  logic [NUM_REGS-1:0]               wr_en_i,
  output logic [NUM_REGS-1:0][NIBBLE_W-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         regs_o[k] <= '0;
      else if (wr_en_i[k]) regs_o[k] <= wr_data_i;
    end
  end
endmodule

// File: rtl/hbd_scan_timer.sv
module hbd_scan_timer #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned TICK_DIV  = 100000,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned CNT_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TICK_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   slot_o <= '0;
    else if (tick) slot_o <= (slot_o == SLOT_LAST) ? '0 : slot_o + 1'b1;
  end
endmodule

// File: rtl/hbd_digit_mux.sv
module hbd_digit_mux
  import hbd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SLOT_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [NUM_REGS-1:0][NIBBLE_W-1:0] regs_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  output seg_t                              seg_o,
  output logic [NUM_REGS-1:0]               an_o
);
  nibble_t sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (slot_i == SLOT_W'(k)) sel = regs_i[k];
    end
  end

  assign seg_o = hex_glyph(sel);

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) an_o[k] = (slot_i != SLOT_W'(k));
  end
endmodule

// File: rtl/hex_bank_display.sv
module hex_bank_display
  import hbd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3:0]          sw_i,
  input  logic [NUM_REGS-1:0] btn_i,
  output logic [7:0]          seg_o,
  output logic [NUM_REGS-1:0] an_o
);
  localparam int unsigned SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][NIBBLE_W-1:0] regs_q;
  logic [SLOT_W-1:0]                 slot;

  hbd_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (sw_i),
    .wr_en_i   (btn_i),
    .regs_o    (regs_q)
  );

  hbd_scan_timer #(.NUM_SLOTS(NUM_REGS), .TICK_DIV(TICK_DIV)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  hbd_digit_mux #(.NUM_REGS(NUM_REGS)) u_mux (
    .regs_i (regs_q),
    .slot_i (slot),
    .seg_o  (seg_o),
    .an_o   (an_o)
  );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned TICK_DIV = 100000
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [3:0]                sw_i,
  input logic [NUM_REGS-1:0]       btn_i,
  input logic [7:0]                seg_o,
  input logic [NUM_REGS-1:0]       an_o,
  input logic [NUM_REGS-1:0][3:0]  regs_q
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0]    dwell_q;
  logic [NUM_REGS-1:0] an_rot;

  assign an_rot = {an_o[NUM_REGS-2:0], an_o[NUM_REGS-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dwell_q <= '0;
    else if (dwell_q == CNT_LAST) dwell_q <= '0;
    else                        dwell_q <= dwell_q + 1'b1;
  end

  assert_one_digit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_o) == 1);

  assert_dp_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[0] == 1'b1);

  assert_glyph_lit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o[7:1] != 7'h7F);

  // rotation check: slot k+1 takes the zero that slot k held
  assert_slot_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwell_q == CNT_LAST) |=> (an_o == $past(an_rot)));

  assert_slot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwell_q != CNT_LAST) |=> $stable(an_o));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg_chk
    assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      btn_i[k] |=> (regs_q[k] == $past(sw_i)));
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !btn_i[k] |=> $stable(regs_q[k]));
  end
endmodule

bind hex_bank_display hbd_checker #(.NUM_REGS(NUM_REGS), .TICK_DIV(TICK_DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sw_i   (sw_i),
  .btn_i  (btn_i),
  .seg_o  (seg_o),
  .an_o   (an_o),
  .regs_q (regs_q)
);

// File: tb/hex_bank_display_bench.sv
module hex_bank_display_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 3;
  localparam int NR    = 4;

  // lit masks per segment, bit v set when value v lights it
  localparam logic [15:0] MA = 16'hD7ED;
  localparam logic [15:0] MB = 16'h279F;
  localparam logic [15:0] MC = 16'h2FFB;
  localparam logic [15:0] MD = 16'h7B6D;
  localparam logic [15:0] ME = 16'hFD45;
  localparam logic [15:0] MF = 16'hDF71;
  localparam logic [15:0] MG = 16'hEF7C;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sw_i = '0;
  logic [3:0] btn_i = '0;
  logic [7:0] seg_o;
  logic [3:0] an_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  hex_bank_display #(.NUM_REGS(NR), .TICK_DIV(DIV)) u_hex_bank_display (
    .clk_i (clk), .rst_ni (rst_ni), .sw_i (sw_i), .btn_i (btn_i),
    .seg_o (seg_o), .an_o (an_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] glyph(input logic [3:0] v);
    return {~MA[v], ~MB[v], ~MC[v], ~MD[v], ~ME[v], ~MF[v], ~MG[v], 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // spec model
  logic [3:0] m_reg [NR];
  int m_cnt, m_slot;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_slot <= 0;
      for (int i = 0; i < NR; i++) m_reg[i] <= '0;
    end else begin
      for (int i = 0; i < NR; i++) if (btn_i[i]) m_reg[i] <= sw_i;
      if (m_cnt == DIV-1) begin m_cnt <= 0; m_slot <= (m_slot + 1) % NR; end
      else m_cnt <= m_cnt + 1;
    end
  end

  logic [3:0] prev_an;
  int run = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      seen = 0; run = 0; prev_an = 4'b1110;
    end else begin
      chk(an_o == ~(4'b1 << m_slot), "R7 digit enable", 32'(an_o), 32'(~(4'b1 << m_slot)));
      chk(seg_o == glyph(m_reg[m_slot]), "R9 slot shows own register", 32'(seg_o), 32'(glyph(m_reg[m_slot])));
      if (an_o != prev_an) begin
        if (seen) chk(run == DIV, "R8 slot length", 32'(run), 32'(DIV));
        seen = 1; run = 1;
      end else run++;
      prev_an = an_o;
    end
  end

  task automatic step(input logic [3:0] sw, input logic [3:0] btn);
    @(negedge clk); #1; sw_i = sw; btn_i = btn;
  endtask

  task automatic wait_slot(input int k);
    do @(negedge clk); while (an_o != ~(4'b1 << k));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(an_o == 4'b1110, "R1 reset enables", 32'(an_o), 32'hE);
    chk(seg_o == 8'h03, "R1 reset glyph", 32'(seg_o), 32'h03);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(an_o == 4'b1110, "R1 after release enables", 32'(an_o), 32'hE);
    chk(seg_o == 8'h03, "R1 after release glyph", 32'(seg_o), 32'h03);

    // full sweep: every value into every register
    for (int r = 0; r < NR; r++) begin
      for (int v = 0; v < 16; v++) begin
        step(4'(v), 4'(1 << r));
        step(~4'(v), 4'h0);
        wait_slot(r);
        chk(seg_o == glyph(4'(v)), "R2 R6 load and glyph", 32'(seg_o), 32'(glyph(4'(v))));
        if (v == 15) chk(seg_o == 8'h71, "R5 F glyph and bit order", 32'(seg_o), 32'h71);
        chk(seg_o[0] == 1'b1, "R5 decimal point off", 32'(seg_o[0]), 32'h1);
      end
    end

    // switches move, buttons idle
    for (int c = 0; c < 24; c++) step(4'(c * 5 + 1), 4'h0);
    for (int k = 0; k < NR; k++) begin
      wait_slot(k);
      chk(seg_o == 8'h71, "R3 held without button", 32'(seg_o), 32'h71);
    end

    // all buttons at once
    step(4'hA, 4'hF);
    step(4'h3, 4'h0);
    for (int k = 0; k < NR; k++) begin
      wait_slot(k);
      chk(seg_o == glyph(4'hA), "R4 multi-load", 32'(seg_o), 32'(glyph(4'hA)));
    end

    // two registers with different values, then reset mid-scan
    step(4'h5, 4'b0010);
    step(4'hC, 4'b0100);
    step(4'h0, 4'h0);
    wait_slot(2);
    chk(seg_o == glyph(4'hC), "R2 independent load", 32'(seg_o), 32'(glyph(4'hC)));
    @(negedge clk); #1 rst_ni = 1'b0;
    @(negedge clk);
    chk(an_o == 4'b1110, "R1 mid-run reset enables", 32'(an_o), 32'hE);
    chk(seg_o == 8'h03, "R1 mid-run reset glyph", 32'(seg_o), 32'h03);
    #1 rst_ni = 1'b1;
    for (int k = 0; k < NR; k++) begin
      wait_slot(k);
      chk(seg_o == 8'h03, "R1 registers cleared", 32'(seg_o), 32'h03);
    end

    repeat (8) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule